// File: doc/BRIEF.md
# EEPROM Page Buffer Commit Unit

This unit sits in front of a small byte-addressed nonvolatile data array. Here the array is modelled as registers, four bytes to a page. A host fills a four-byte staging buffer through a load port. Each loaded byte position is marked. A page-write command then copies only the marked positions into the chosen page. Every other byte of that page keeps its old contents. The unit also accepts single-byte writes and an erase of the whole array to 0xFF. Every stored byte is replaced outright, so it needs no prior erase.

Each accepted operation starts a self-timed busy window. Its length is a whole number of milliseconds, counted in clock cycles through a cycles-per-millisecond parameter. The array is updated only at the end of the window. Reads therefore keep returning the old data until busy drops. A request made while busy is dropped and sets a sticky error flag. So is any request that loses to a higher-priority request in the same idle cycle.

Top module: `eeprom_page_commit`

## Requirements
- R1: The array holds MEM_BYTES bytes (128, 256 or 512). An address splits into a page number in bits [ADDR_W-1:2] and a byte offset in bits [1:0], so the top page is MEM_BYTES/4-1.
- R2: With loadEn high, loadData is stored in buffer slot loadOff and that slot is marked loaded. A later load to the same slot replaces the value.
- R3: An accepted page write changes only the loaded slots of page pageAddr, at addresses pageAddr*4+slot. All other bytes of the array keep their values.
- R4: All loaded marks clear when a page write is accepted. A load in that same cycle goes into the following page write, not the current one. A page write with no slots loaded changes nothing.
- R5: An accepted byte write stores byteData at byteAddr and leaves every other byte unchanged.
- R6: An accepted erase sets every byte of the array to 0xFF.
- R7: busy rises in the cycle after a request is accepted. It stays high for WRITE_MS*CYC_PER_MS cycles after a byte or page write, and for ERASE_MS*CYC_PER_MS cycles after an erase. The array changes on the clock edge at which busy falls.
- R8: rdData gives the byte at rdAddr one cycle after rdAddr is presented. While busy is high, it returns the contents from before the pending operation.
- R9: A page-write, byte-write or erase request made while busy is high is ignored and sets err. err stays set until reset.
- R10: When several requests arrive in one idle cycle, erase wins over page write, and page write wins over byte write. The losing requests are dropped and err is set.
- R11: Reset clears busy, err and all loaded marks. It sets every array byte to 0xFF, and rdData to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load one byte into the page buffer |
| loadOff | input | 2 | Buffer slot (byte offset in page) |
| loadData | input | 8 | Byte to load |
| pageWrEn | input | 1 | Commit the buffer to a page |
| pageAddr | input | ADDR_W-2 | Page number for the commit |
| byteWrEn | input | 1 | Single-byte write request |
| byteAddr | input | ADDR_W | Byte address for the single write |
| byteData | input | 8 | Byte for the single write |
| eraseEn | input | 1 | Erase the whole array to 0xFF |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data, one cycle latency |
| busy | output | 1 | Self-timed operation in progress |
| err | output | 1 | Sticky flag for a rejected request |

## Verification
A buffer load and an accepted page write can happen in the same cycle. The bench provokes this by pulsing loadEn and pageWrEn together into an empty buffer. It judges the result at the read port. The target page must stay all 0xFF, and a later commit to another page must carry the coinciding byte. A second coincidence, a page write and a byte write presented together, is judged the same way. The loaded byte must land, the byte-write address must stay 0xFF, and err must rise.

// File: rtl/eepb_pkg.sv
package eepb_pkg;
  // Strobes passed from control to datapath, at most one take per cycle
  typedef struct packed {
    logic takeErase;
    logic takePage;
    logic takeByte;
    logic commit;
  } eepbStrobe_t;
endpackage

// File: rtl/eepb_ctrl.sv
module eepb_ctrl
  import eepb_pkg::*;
#(
  parameter int WR_CYC = 4000,
  parameter int ER_CYC = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pageWrEn,
  input  logic        byteWrEn,
  input  logic        eraseEn,
  output eepbStrobe_t strobe,
  output logic        busy,
  output logic        err
);
  localparam int MAX_CYC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             anyReq;
  logic             multiReq;

  always_comb begin
    anyReq           = pageWrEn | byteWrEn | eraseEn;
    multiReq         = (pageWrEn & byteWrEn) | (pageWrEn & eraseEn) | (byteWrEn & eraseEn);
    strobe.takeErase = !busy && eraseEn;
    strobe.takePage  = !busy && pageWrEn && !eraseEn;
    strobe.takeByte  = !busy && byteWrEn && !eraseEn && !pageWrEn;
    strobe.commit    = busy && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      err  <= 1'b0;
    end else begin
      if (strobe.takeErase) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ER_CYC);
      end else if (strobe.takePage || strobe.takeByte) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WR_CYC);
      end else if (strobe.commit) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt  <= cnt - CNT_W'(1);
      end
      if ((busy && anyReq) || (!busy && multiReq)) err <= 1'b1;
    end
  end
endmodule

// File: rtl/eepb_dpath.sv
module eepb_dpath
  import eepb_pkg::*;
#(
  parameter int MEM_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  eepbStrobe_t                   strobe,
  input  logic                          loadEn,
  input  logic [1:0]                    loadOff,
  input  logic [7:0]                    loadData,
  input  logic [$clog2(MEM_BYTES)-3:0]  pageAddr,
  input  logic [$clog2(MEM_BYTES)-1:0]  byteAddr,
  input  logic [7:0]                    byteData,
  input  logic [$clog2(MEM_BYTES)-1:0]  rdAddr,
  output logic [7:0]                    rdData
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = ADDR_W - 2;
  localparam int PAGES  = MEM_BYTES / 4;

  logic [3:0][7:0]    bufData;
  logic [3:0]         bufLoaded;
  logic [PAGE_W-1:0]  pendPage;
  logic [3:0]         pendMask;
  logic [3:0][7:0]    pendData;
  logic               pendErase;
  logic [3:0][7:0]    pageView [PAGES];

  // Staging buffer: a load in the commit cycle survives the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData   <= '0;
      bufLoaded <= '0;
    end else begin
      if (strobe.takePage) bufLoaded <= '0;
      if (loadEn) begin
        bufData[loadOff]   <= loadData;
        bufLoaded[loadOff] <= 1'b1;
      end
    end
  end

  // Snapshot of the accepted operation, applied when the timer ends
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPage  <= '0;
      pendMask  <= '0;
      pendData  <= '0;
      pendErase <= 1'b0;
    end else if (strobe.takeErase) begin
      pendErase <= 1'b1;
      pendMask  <= '0;
    end else if (strobe.takePage) begin
      pendErase <= 1'b0;
      pendPage  <= pageAddr;
      pendMask  <= bufLoaded;
      pendData  <= bufData;
    end else if (strobe.takeByte) begin
      pendErase <= 1'b0;
      pendPage  <= byteAddr[ADDR_W-1:2];
      pendMask  <= 4'(1) << byteAddr[1:0];
      pendData  <= {4{byteData}};
    end
  end

  // Array: one register group per page, each lane replaced outright
  for (genvar p = 0; p < PAGES; p++) begin : gPage
    logic [3:0][7:0] cells;
    logic            hit;
    assign hit = strobe.commit && (pendPage == PAGE_W'(p));
    for (genvar j = 0; j < 4; j++) begin : gLane
      always_ff @(posedge clk) begin
        if (!rstN) cells[j] <= 8'hFF;
        else if (strobe.commit && pendErase) cells[j] <= 8'hFF;
        else if (hit && pendMask[j]) cells[j] <= pendData[j];
      end
    end
    assign pageView[p] = cells;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'hFF;
    else       rdData <= pageView[rdAddr[ADDR_W-1:2]][rdAddr[1:0]];
  end
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import eepb_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int CYC_PER_MS = 1000,
  parameter int WRITE_MS   = 4,
  parameter int ERASE_MS   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          loadEn,
  input  logic [1:0]                    loadOff,
  input  logic [7:0]                    loadData,
  input  logic                          pageWrEn,
  input  logic [$clog2(MEM_BYTES)-3:0]  pageAddr,
  input  logic                          byteWrEn,
  input  logic [$clog2(MEM_BYTES)-1:0]  byteAddr,
  input  logic [7:0]                    byteData,
  input  logic                          eraseEn,
  input  logic [$clog2(MEM_BYTES)-1:0]  rdAddr,
  output logic [7:0]                    rdData,
  output logic                          busy,
  output logic                          err
);
  localparam int WR_CYC = WRITE_MS * CYC_PER_MS;
  localparam int ER_CYC = ERASE_MS * CYC_PER_MS;

  eepbStrobe_t strobe;

  eepb_ctrl #(.WR_CYC(WR_CYC), .ER_CYC(ER_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .pageWrEn(pageWrEn), .byteWrEn(byteWrEn),
    .eraseEn(eraseEn), .strobe(strobe), .busy(busy), .err(err)
  );

  eepb_dpath #(.MEM_BYTES(MEM_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadEn(loadEn), .loadOff(loadOff),
    .loadData(loadData), .pageAddr(pageAddr), .byteAddr(byteAddr),
    .byteData(byteData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/eepb_chk.sv
module eepb_chk #(
  parameter int ADDR_W = 7,
  parameter int WR_CYC = 4000,
  parameter int ER_CYC = 4000
) (
  input logic              clk,
  input logic              rstN,
  input logic              pageWrEn,
  input logic              byteWrEn,
  input logic              eraseEn,
  input logic              busy,
  input logic              err,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData
);
  logic [31:0] busyLen;
  logic        isErase;
  logic        anyReq;

  assign anyReq = pageWrEn | byteWrEn | eraseEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen <= '0;
      isErase <= 1'b0;
    end else begin
      busyLen <= busy ? busyLen + 32'd1 : 32'd0;
      if (!busy && eraseEn) isErase <= 1'b1;
      else if (!busy && anyReq) isErase <= 1'b0;
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == (isErase ? 32'(ER_CYC) : 32'(WR_CYC))); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && anyReq) |=> busy); // R7
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyReq) |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    err |=> err); // R9
  AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $countones({pageWrEn, byteWrEn, eraseEn}) > 1) |=> err); // R10
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && $past(rdAddr) == $past(rdAddr, 2)) |-> $stable(rdData)); // R8
endmodule

bind eeprom_page_commit eepb_chk #(
  .ADDR_W($clog2(MEM_BYTES)), .WR_CYC(WR_CYC), .ER_CYC(ER_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .pageWrEn(pageWrEn), .byteWrEn(byteWrEn),
  .eraseEn(eraseEn), .busy(busy), .err(err), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/sim_eeprom_page_commit.sv
module sim_eeprom_page_commit;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 128;
  localparam int ADDR_W     = 7;
  localparam int CYC_PER_MS = 3;
  localparam int WR_LEN     = 4 * CYC_PER_MS;
  localparam int ER_LEN     = 2 * CYC_PER_MS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [1:0] loadOff = '0;
  logic [7:0] loadData = '0;
  logic pageWrEn = 1'b0;
  logic [ADDR_W-3:0] pageAddr = '0;
  logic byteWrEn = 1'b0;
  logic [ADDR_W-1:0] byteAddr = '0;
  logic [7:0] byteData = '0;
  logic eraseEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic busy, err;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_commit #(.MEM_BYTES(MEM_BYTES), .CYC_PER_MS(CYC_PER_MS),
                       .WRITE_MS(4), .ERASE_MS(2)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadOff(loadOff), .loadData(loadData),
    .pageWrEn(pageWrEn), .pageAddr(pageAddr), .byteWrEn(byteWrEn),
    .byteAddr(byteAddr), .byteData(byteData), .eraseEn(eraseEn),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .err(err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tick(); tick(); rstN = 1'b1;
  endtask

  task automatic rd(input int a, output int v);
    rdAddr = ADDR_W'(a); tick(); v = int'(rdData);
  endtask

  task automatic checkByte(string tag, int a, int exp);
    int v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin n++; tick(); end
  endtask

  task automatic load(int off, int d);
    loadEn = 1'b1; loadOff = 2'(off); loadData = 8'(d); tick(); loadEn = 1'b0;
  endtask

  task automatic byteWrite(int a, int d);
    byteWrEn = 1'b1; byteAddr = ADDR_W'(a); byteData = 8'(d); tick(); byteWrEn = 1'b0;
  endtask

  task automatic pageWrite(int p);
    pageWrEn = 1'b1; pageAddr = (ADDR_W-2)'(p); tick(); pageWrEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 busy after reset", int'(busy), 0);
    check("R11 err after reset", int'(err), 0);
    check("R11 rdData after reset", int'(rdData), 8'hFF);
    checkByte("R11 array erased", 5, 8'hFF);
  endtask

  task automatic t_byteWrite();
    int n;
    byteWrite(9, 8'h3C);
    waitIdle(n);
    check("R7 write busy length", n, WR_LEN);
    checkByte("R5 byte stored", 9, 8'h3C);
    checkByte("R5 left neighbour", 8, 8'hFF);
    checkByte("R5 right neighbour", 10, 8'hFF);
  endtask

  task automatic t_readDuringBusy();
    int n;
    byteWrite(9, 8'h5D);
    checkByte("R8 old value during busy", 9, 8'h3C);
    check("R8 still busy", int'(busy), 1);
    waitIdle(n);
    checkByte("R8 new value after busy", 9, 8'h5D);
  endtask

  task automatic t_pageCommit();
    int n;
    load(0, 8'h11); load(2, 8'h22); load(2, 8'h33);
    pageWrite(2);
    waitIdle(n);
    check("R7 page busy length", n, WR_LEN);
    checkByte("R3 slot0 loaded", 8, 8'h11);
    checkByte("R3 slot1 untouched", 9, 8'h5D);
    checkByte("R2 slot2 last load wins", 10, 8'h33);
    checkByte("R3 slot3 untouched", 11, 8'hFF);
    checkByte("R3 next page untouched", 12, 8'hFF);
    check("R9 no err on legal use", int'(err), 0);
  endtask

  task automatic t_coincide();
    int n;
    loadEn = 1'b1; loadOff = 2'd1; loadData = 8'h44;
    pageWrEn = 1'b1; pageAddr = 5'd5;
    tick();
    loadEn = 1'b0; pageWrEn = 1'b0;
    waitIdle(n);
    for (int a = 20; a < 24; a++) checkByte("R4 empty commit changes nothing", a, 8'hFF);
    pageWrite(6);
    waitIdle(n);
    checkByte("R4 coinciding load in next commit", 25, 8'h44);
    checkByte("R4 other slot of next commit", 24, 8'hFF);
  endtask

  task automatic t_topPage();
    int n;
    byteWrite(127, 8'h5A);
    waitIdle(n);
    load(0, 8'hC3);
    pageWrite(31);
    waitIdle(n);
    checkByte("R1 top page slot0", 124, 8'hC3);
    checkByte("R1 top address kept", 127, 8'h5A);
    checkByte("R1 top page slot1", 125, 8'hFF);
  endtask

  task automatic t_priority();
    int n;
    doReset();
    load(3, 8'h99);
    pageWrEn = 1'b1; pageAddr = 5'd3;
    byteWrEn = 1'b1; byteAddr = 7'd50; byteData = 8'h77;
    tick();
    pageWrEn = 1'b0; byteWrEn = 1'b0;
    waitIdle(n);
    check("R10 page wins busy length", n, WR_LEN);
    checkByte("R10 page commit done", 15, 8'h99);
    checkByte("R10 byte write dropped", 50, 8'hFF);
    check("R10 err on collision", int'(err), 1);
    eraseEn = 1'b1; byteWrEn = 1'b1; byteAddr = 7'd51; byteData = 8'h12;
    tick();
    eraseEn = 1'b0; byteWrEn = 1'b0;
    waitIdle(n);
    check("R7 erase busy length", n, ER_LEN);
    checkByte("R6 erase clears page data", 15, 8'hFF);
    checkByte("R10 byte dropped under erase", 51, 8'hFF);
  endtask

  task automatic t_reject();
    int n;
    doReset();
    check("R11 err cleared by reset", int'(err), 0);
    byteWrite(40, 8'hAA);
    byteWrite(41, 8'h55);
    eraseEn = 1'b1; tick(); eraseEn = 1'b0;
    pageWrite(10);
    waitIdle(n);
    check("R9 rejected requests no extra busy", int'(busy), 0);
    checkByte("R9 first write kept", 40, 8'hAA);
    checkByte("R9 rejected byte write", 41, 8'hFF);
    check("R9 err set", int'(err), 1);
    repeat (5) tick();
    check("R9 err sticky", int'(err), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;
    t_reset();
    t_byteWrite();
    t_readDuringBusy();
    t_pageCommit();
    t_coincide();
    t_topPage();
    t_priority();
    t_reject();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule